// File: doc/BRIEF.md
# MDIO Management Master with Single-Word Control

This block is a Clause 22 MDIO management master. Software runs it through one 32-bit control word. One write to that word carries the whole transaction: the target PHY address, the register within that PHY, the direction, the write data, an enable bit and a busy bit. Setting busy together with the enable bit starts the frame. The hardware clears busy once the last bit has been clocked, so the same bit serves as the start strobe and as the completion flag.

While a frame runs, the block divides the system clock down to MDC. It shifts the frame out on MDIO and drives an output-enable for an external tristate pad. On a read it releases the line for the turnaround and data phases, shifts in the 16 bits returned by the PHY, and places them in the low half of the control word.

Top module: `mdio_ctl_master`

## Requirements
- R1: The control word keeps bit 31 (busy), bit 30 (enable), bit 27 (direction: 1 read, 0 write), bits 25:21 (PHY address), bits 20:16 (register address) and bits 15:0 (data). All other bits read back as 0. The reset value is all zeros.
- R2: A write with bit 31 and bit 30 both set, made while idle, starts a frame. Bit 31 reads 1 from the next cycle until the frame completes, and then reads 0.
- R3: A write with bit 31 set and bit 30 clear starts no frame. Busy reads 0 afterwards and MDC produces no edge.
- R4: Every frame is 64 MDC periods long. It sends 32 one-bits, then 0 1, then the opcode (0 1 for a write, 1 0 for a read), then the PHY address and the register address, each MSB first.
- R5: In a write frame, the turnaround bits are 1 then 0 and are followed by bits 15:0 MSB first. The output enable stays high for all 64 bits.
- R6: In a read frame, the output enable is low for the last 18 bits. The 16 data bits are sampled on the rising MDC edges, MSB first, and bits 15:0 of the control word hold them when busy clears.
- R7: MDC has a period of DIV system clocks with DIV/2 clocks high. It is held low while idle.
- R8: MDIO and its output enable change only while MDC is low.
- R9: A write to the control word while busy reads 1 is ignored. The running frame and the stored fields are unchanged.
- R10: After reset, MDC is low and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Write strobe for the control word |
| reg_wdata_i | input | 32 | Control word write value |
| reg_rdata_o | output | 32 | Control word read value |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable for the pad |
| mdio_i | input | 1 | MDIO line as seen at the pad |

## Verification
The bench's PHY responder drives read data of all zeros, all ones and random values. A deserializer that is off by one edge would show a shifted result. A responder that never drives would give all ones.

PHY and register addresses of all ones and all zeros are mixed in, to catch field misplacement and bit-order reversal in the header. A write issued mid-frame with different fields must leave both the captured frame and the readback untouched; a design that accepted it would corrupt the header or drop busy early. An enable-less start must leave MDC silent and busy clear; a design that ignored the enable would run a frame.

// File: rtl/mdio_ctl_pkg.sv
package mdio_ctl_pkg;
  localparam int unsigned BUSY_BIT   = 31;
  localparam int unsigned EN_BIT     = 30;
  localparam int unsigned RD_BIT     = 27;
  localparam int unsigned PHY_LSB    = 21;
  localparam int unsigned REG_LSB    = 16;
  localparam int unsigned ADDR_W     = 5;
  localparam int unsigned DATA_W     = 16;
  localparam int unsigned FRAME_BITS = 64;
  localparam int unsigned TA_IDX     = 46;
  localparam int unsigned DATA_IDX   = 48;
  localparam logic [31:0] KEEP_MASK  = 32'hCBFF_FFFF;

  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic rd, input logic [ADDR_W-1:0] phy, input logic [ADDR_W-1:0] rga,
    input logic [DATA_W-1:0] wd);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rga,
            (rd ? 2'b00 : 2'b10), (rd ? {DATA_W{1'b0}} : wd)};
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned HALF = DIV / 2;
  localparam int unsigned CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          wrap;

  assign wrap   = run_i && (cnt_q == CW'(HALF - 1));
  assign rise_o = wrap && !mdc_q;
  assign fall_o = wrap && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] phy_i,
  input  logic [ADDR_W-1:0] reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned BW = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] sr_q;
  logic [BW-1:0]         bcnt_q;
  logic                  active_q, rd_q;
  logic [DATA_W-1:0]     rsh_q;
  logic                  last_bit;

  assign last_bit  = (bcnt_q == BW'(FRAME_BITS - 1));
  assign done_o    = active_q && fall_i && last_bit;
  assign mdio_o    = active_q & sr_q[FRAME_BITS-1];
  assign mdio_oe_o = active_q && !(rd_q && (bcnt_q >= BW'(TA_IDX)));
  assign rdata_o   = rsh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q     <= '0;
      bcnt_q   <= '0;
      active_q <= 1'b0;
      rd_q     <= 1'b0;
      rsh_q    <= '0;
    end else if (start_i) begin
      sr_q     <= build_frame(rd_i, phy_i, reg_i, wdata_i);
      bcnt_q   <= '0;
      active_q <= 1'b1;
      rd_q     <= rd_i;
    end else if (active_q) begin
      // sample on the rising edge; shift on the falling edge
      if (rise_i && rd_q && (bcnt_q >= BW'(DATA_IDX)))
        rsh_q <= {rsh_q[DATA_W-2:0], mdio_i};
      if (fall_i) begin
        if (last_bit) active_q <= 1'b0;
        else begin
          bcnt_q <= bcnt_q + 1'b1;
          sr_q   <= {sr_q[FRAME_BITS-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/mdio_ctl_master.sv
module mdio_ctl_master
  import mdio_ctl_pkg::*;
#(
  parameter int unsigned DIV = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic [31:0]       ctrl_q;
  logic              busy, start, go;
  logic              rise, fall, done;
  logic [DATA_W-1:0] eng_rdata;

  assign busy        = ctrl_q[BUSY_BIT];
  assign go          = reg_wdata_i[BUSY_BIT] && reg_wdata_i[EN_BIT];
  assign start       = reg_we_i && !busy && go;
  assign reg_rdata_o = ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (reg_we_i && !busy) begin
      ctrl_q           <= reg_wdata_i & KEEP_MASK;
      ctrl_q[BUSY_BIT] <= go;
    end else if (done) begin
      ctrl_q[BUSY_BIT] <= 1'b0;
      if (ctrl_q[RD_BIT]) ctrl_q[DATA_W-1:0] <= eng_rdata;
    end
  end

  mdio_mdc_gen #(.DIV(DIV)) u_mdc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_frame_eng u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .rd_i      (reg_wdata_i[RD_BIT]),
    .phy_i     (reg_wdata_i[PHY_LSB +: ADDR_W]),
    .reg_i     (reg_wdata_i[REG_LSB +: ADDR_W]),
    .wdata_i   (reg_wdata_i[DATA_W-1:0]),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .done_o    (done),
    .rdata_o   (eng_rdata)
  );
endmodule

// File: rtl/mdio_ctl_master_chk.sv
module mdio_ctl_master_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_we_i,
  input logic [31:0] reg_wdata_i,
  input logic [31:0] reg_rdata_o,
  input logic        mdc_o,
  input logic        mdio_o,
  input logic        mdio_oe_o
);
  // R8
  a_r8_mdio_stable_mdc_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_o && $past(mdc_o)) |-> ($stable(mdio_o) && $stable(mdio_oe_o)));

  // R7
  a_r7_idle_mdc_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rdata_o[31] |-> (!mdc_o && !mdio_oe_o));

  // R9
  a_r9_write_while_busy_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_rdata_o[31]) |=> $stable(reg_rdata_o[30:16]));

  // R2
  a_r2_start_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !reg_rdata_o[31] && reg_wdata_i[31] && reg_wdata_i[30]) |=> reg_rdata_o[31]);

  // R3
  a_r3_no_enable_no_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !reg_rdata_o[31] && !reg_wdata_i[30]) |=> (!reg_rdata_o[31] && !mdc_o));
endmodule

bind mdio_ctl_master mdio_ctl_master_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .mdc_o       (mdc_o),
  .mdio_o      (mdio_o),
  .mdio_oe_o   (mdio_oe_o)
);

// File: tb/mdio_ctl_master_bench.sv
module mdio_ctl_master_bench;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        mdc_o, mdio_o, mdio_oe_o, mdio_i;

  int checks = 0, failures = 0;
  int ridx = 0;
  logic [63:0] cap_val, cap_oe;
  logic        phy_en = 1'b0, phy_bit = 1'b1, read_mode = 1'b0;
  logic [15:0] resp = '0;
  int cyc = 0, last_rise = 0, last_fall = 0, per = 0, high_t = 0;
  int viol = 0;
  logic prev_mdc = 1'b0, prev_mdio = 1'b0, prev_oe = 1'b0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign mdio_i = mdio_oe_o ? mdio_o : (phy_en ? phy_bit : 1'b1);

  mdio_ctl_master #(.DIV(DIV)) u_mdio_ctl_master (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .mdc_o(mdc_o), .mdio_o(mdio_o),
    .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i));

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge mdc_o) begin
    if (ridx < 64) begin
      cap_val[63-ridx] = mdio_i;
      cap_oe[63-ridx]  = mdio_oe_o;
    end
    ridx = ridx + 1;
    per = cyc - last_rise;
    last_rise = cyc;
  end

  always @(negedge mdc_o) begin
    high_t = cyc - last_rise;
    last_fall = cyc;
    if (read_mode && ridx >= 48 && ridx <= 63) begin
      phy_en = 1'b1; phy_bit = resp[15-(ridx-48)];
    end else if (read_mode && ridx == 47) begin
      phy_en = 1'b1; phy_bit = 1'b0;
    end else phy_en = 1'b0;
  end

  // R8 monitor
  always @(negedge clk) begin
    if (rst_ni && prev_mdc && mdc_o && (mdio_o !== prev_mdio || mdio_oe_o !== prev_oe))
      viol = viol + 1;
    prev_mdc = mdc_o; prev_mdio = mdio_o; prev_oe = mdio_oe_o;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(input logic [31:0] w);
    logic rd = w[27];
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), w[25:21], w[20:16],
            (rd ? 2'b00 : 2'b10), (rd ? resp : w[15:0])};
  endfunction

  function automatic logic [63:0] exp_oe(input logic rd);
    return rd ? {46'h3FFF_FFFF_FFFF, 18'h0} : 64'hFFFF_FFFF_FFFF_FFFF;
  endfunction

  task automatic wr(input logic [31:0] w);
    @(negedge clk); reg_we_i = 1'b1; reg_wdata_i = w;
    @(negedge clk); reg_we_i = 1'b0;
  endtask

  task automatic xfer(input logic [31:0] w, input logic [15:0] r, input bit poke);
    logic [31:0] expw;
    int n;
    ridx = 0; read_mode = w[27]; resp = r;
    wr(w);
    check("R2 busy set", {63'b0, reg_rdata_o[31]}, 64'd1);
    if (poke) begin
      repeat (20 * DIV) @(negedge clk);
      wr(~w | 32'h8000_0000);  // R9: write while busy
    end
    n = 0;
    while (reg_rdata_o[31] && n < 64 * DIV + 50) begin @(negedge clk); n++; end
    check("R2 busy cleared", {63'b0, reg_rdata_o[31]}, 64'd0);
    check(w[27] ? "R4/R6 read frame" : "R4/R5 write frame",
          w[27] ? (cap_val & exp_oe(1'b1)) | {48'b0, cap_val[15:0]} : cap_val,
          w[27] ? (exp_frame(w) & exp_oe(1'b1)) | {48'b0, r} : exp_frame(w));
    check(w[27] ? "R6 oe released" : "R5 oe held", cap_oe, exp_oe(w[27]));
    check("R4 64 mdc periods", 64'(ridx), 64'd64);
    expw = w & 32'h4BFF_FFFF;
    if (w[27]) expw[15:0] = r;
    check(poke ? "R9 readback after ignored write" : "R1/R6 readback",
          {32'b0, reg_rdata_o}, {32'b0, expw});
    check("R7 mdc period", 64'(per), 64'(DIV));
    check("R7 mdc high time", 64'(high_t), 64'(DIV/2));
    read_mode = 1'b0; phy_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] w;
    int seed;
    seed = $urandom(32'h5EED);
    #1;
    check("R10 reset mdc", {63'b0, mdc_o}, 64'd0);
    check("R10 reset oe", {63'b0, mdio_oe_o}, 64'd0);
    check("R1 reset word", {32'b0, reg_rdata_o}, 64'd0);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    // R1: unused bits masked (no busy)
    wr(32'h3FFF_FFFF);
    check("R1 field mask", {32'b0, reg_rdata_o}, {32'b0, 32'h4BFF_FFFF & 32'h3FFF_FFFF});

    // R3: busy without enable
    ridx = 0;
    wr(32'h8000_1234);
    repeat (10 * DIV) @(negedge clk);
    check("R3 busy stays clear", {63'b0, reg_rdata_o[31]}, 64'd0);
    check("R3 no mdc edge", 64'(ridx), 64'd0);

    // directed corners
    xfer(32'hC3FF_FFFF, 16'h0, 1'b0);           // write, all-ones addr/data
    xfer(32'hC800_0000, 16'hFFFF, 1'b0);        // read phy0 reg0 all ones
    xfer(32'hCBFF_0000, 16'h0000, 1'b0);        // read addr all ones, zero data
    xfer(32'hC8A5_0000, 16'hA55A, 1'b1);        // read with write while busy
    xfer(32'hC04A_5A5A, 16'h0, 1'b1);           // write with write while busy

    for (int i = 0; i < 6; i++) begin
      w = $urandom;
      w[31] = 1'b1; w[30] = 1'b1;
      xfer(w, 16'($urandom), 1'b0);
    end

    check("R8 mdio changes only with mdc low", 64'(viol), 64'd0);
    finish_run();
  end
endmodule